// File: doc/BRIEF.md
# Configuration Checksum Writer

This block produces two 8-bit CRC values for a 20-byte configuration register file and stores them back into that file. The file sits outside the block. The block reaches it through a synchronous read port with one cycle of latency and a single-cycle write port. A one-cycle start request launches the job.

The first CRC covers the setup bytes at addresses 0 to 11 and lands in address 12. The second CRC covers the offset bytes at addresses 13 to 18 and lands in address 19. Both calculations load the seed value 0x02. Each takes one data bit per clock, most significant bit first, using the polynomial x^8+x^4+x^3+x^2+1. A pulse on the done output closes the job.

The block fits after any software or host step that edits the register file. The edit is then followed by one start pulse so that the stored checksums match again.

Top module: `cfg_crc_gen`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, busy, read enable, write enable and done are all low.
- R2: Address 12 receives the CRC of bytes 0..11. The CRC register is loaded with 0x02. For each bit, taken MSB first, the register shifts left by one and keeps 8 bits. It is XORed with 0x1D when the register's old top bit differs from the data bit.
- R3: Address 19 receives the CRC of bytes 13..18, calculated by the same rule from a fresh 0x02 seed. Its value does not depend on bytes 0..12.
- R4: The reads go out in ascending order: addresses 0..11, then the address-12 write, then addresses 13..18. Each byte is read exactly once, and addresses 12 and 19 are never read.
- R5: The byte on the read-data input is used only in the cycle right after its read enable. Values presented in any other cycle have no effect.
- R6: The first read enable comes one cycle after start is sampled. Consecutive reads within one range are 10 cycles apart, and a result write follows the last read of its range by 10 cycles.
- R7: Busy is high from the cycle after start until the job ends. Done is a one-cycle pulse in the cycle after the address-19 write, with busy already low.
- R8: A start request while busy is ignored: the job still issues exactly 18 reads and 2 writes, in the order of R4.
- R9: Only addresses 12 and 19 are ever written, and read and write enables are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, one cycle |
| busy_o | output | 1 | High while a job is running |
| done_o | output | 1 | One-cycle pulse after both results are stored |
| rd_en_o | output | 1 | Read request to the register file |
| rd_addr_o | output | 5 | Read address |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_en_o |
| wr_en_o | output | 1 | Write request to the register file |
| wr_addr_o | output | 5 | Write address (12 or 19) |
| wr_data_o | output | 8 | Checksum being written |

## Verification
The start input and the running job can fall in the same cycle. The bench fires a stray start request at a random point inside a running job and checks that the read/write trace and the stored values match an undisturbed run. The setup-result write and the first offset read also fall in adjacent cycles and share the CRC register. The bench checks that the address-13 read follows the address-12 write by exactly one cycle. It also checks that the offset CRC is correct, which shows the reseed did not corrupt the stored value. Between reads the memory model drives random bytes, so any sampling outside the one valid cycle shows up as a wrong checksum.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CAPT,
    ST_SHIFT,
    ST_WRITE
  } seq_state_t;
endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic [W-1:0] crc_i,
  input  logic         din_i,
  output logic [W-1:0] crc_o
);
  logic fb;
  assign fb = crc_i[W-1] ^ din_i;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign crc_o[i] = fb & POLY[i];
    end else begin : g_up
      assign crc_o[i] = crc_i[i-1] ^ (fb & POLY[i]);
    end
  end
endmodule

// File: rtl/crc_byte_lane.sv
module crc_byte_lane #(
  parameter int           W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D,
  parameter logic [W-1:0] SEED = 8'h02
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_i,
  input  logic         capt_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_next_o
);
  logic [W-1:0] crc_q;
  logic [W-1:0] byte_q;

  crc_bit_step #(.W(W), .POLY(POLY)) u_step (
    .crc_i (crc_q),
    .din_i (byte_q[W-1]),
    .crc_o (crc_next_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q  <= '0;
      byte_q <= '0;
    end else begin
      if (seed_i)       crc_q <= SEED;
      else if (shift_i) crc_q <= crc_next_o;
      if (capt_i)       byte_q <= data_i;
      else if (shift_i) byte_q <= {byte_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
  import cfg_crc_pkg::*;
#(
  parameter int W         = 8,
  parameter int ADDR_W    = 5,
  parameter int CFG_FIRST = 0,
  parameter int CFG_LAST  = 11,
  parameter int CFG_SLOT  = 12,
  parameter int OFS_FIRST = 13,
  parameter int OFS_LAST  = 18,
  parameter int OFS_SLOT  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [W-1:0]      crc_next_i,
  output logic              seed_o,
  output logic              capt_o,
  output logic              shift_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [W-1:0]      wr_data_o
);
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  seq_state_t       state_q;
  logic             seg_q;
  logic [BIT_W-1:0] bit_q;
  logic [ADDR_W-1:0] seg_last, seg_slot;

  assign seg_last = seg_q ? ADDR_W'(OFS_LAST) : ADDR_W'(CFG_LAST);
  assign seg_slot = seg_q ? ADDR_W'(OFS_SLOT) : ADDR_W'(CFG_SLOT);

  assign seed_o  = ((state_q == ST_IDLE) && start_i) ||
                   ((state_q == ST_WRITE) && !seg_q);
  assign capt_o  = (state_q == ST_CAPT);
  assign shift_o = (state_q == ST_SHIFT);
  assign busy_o  = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      seg_q     <= 1'b0;
      bit_q     <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      rd_en_o <= 1'b0;
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            seg_q     <= 1'b0;
            rd_addr_o <= ADDR_W'(CFG_FIRST);
            rd_en_o   <= 1'b1;
            state_q   <= ST_LOAD;
          end
        end
        ST_LOAD: state_q <= ST_CAPT;
        ST_CAPT: begin
          bit_q   <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          bit_q <= bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            if (rd_addr_o == seg_last) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= seg_slot;
              wr_data_o <= crc_next_i;
              state_q   <= ST_WRITE;
            end else begin
              rd_addr_o <= rd_addr_o + 1'b1;
              rd_en_o   <= 1'b1;
              state_q   <= ST_LOAD;
            end
          end
        end
        ST_WRITE: begin
          if (!seg_q) begin
            seg_q     <= 1'b1;
            rd_addr_o <= ADDR_W'(OFS_FIRST);
            rd_en_o   <= 1'b1;
            state_q   <= ST_LOAD;
          end else begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_crc_gen.sv
module cfg_crc_gen #(
  parameter int           W         = 8,
  parameter int           ADDR_W    = 5,
  parameter logic [W-1:0] POLY      = 8'h1D,
  parameter logic [W-1:0] SEED      = 8'h02,
  parameter int           CFG_FIRST = 0,
  parameter int           CFG_LAST  = 11,
  parameter int           CFG_SLOT  = 12,
  parameter int           OFS_FIRST = 13,
  parameter int           OFS_LAST  = 18,
  parameter int           OFS_SLOT  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [W-1:0]      rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [W-1:0]      wr_data_o
);
  logic         seed_w, capt_w, shift_w;
  logic [W-1:0] crc_next_w;

  crc_byte_lane #(.W(W), .POLY(POLY), .SEED(SEED)) u_lane (
    .clk        (clk),
    .rst        (rst),
    .seed_i     (seed_w),
    .capt_i     (capt_w),
    .shift_i    (shift_w),
    .data_i     (rd_data_i),
    .crc_next_o (crc_next_w)
  );

  crc_seq_ctrl #(
    .W(W), .ADDR_W(ADDR_W),
    .CFG_FIRST(CFG_FIRST), .CFG_LAST(CFG_LAST), .CFG_SLOT(CFG_SLOT),
    .OFS_FIRST(OFS_FIRST), .OFS_LAST(OFS_LAST), .OFS_SLOT(OFS_SLOT)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .crc_next_i (crc_next_w),
    .seed_o     (seed_w),
    .capt_o     (capt_w),
    .shift_o    (shift_w),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );
endmodule

// File: rtl/cfg_crc_chk.sv
module cfg_crc_chk #(
  parameter int ADDR_W    = 5,
  parameter int CFG_SLOT  = 12,
  parameter int OFS_FIRST = 13,
  parameter int OFS_SLOT  = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o
);
  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_o && wr_en_o));

  assert_wr_slot_only_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_addr_o == ADDR_W'(CFG_SLOT) || wr_addr_o == ADDR_W'(OFS_SLOT)));

  assert_single_read_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> !rd_en_o);

  assert_cfg_then_ofs_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o == ADDR_W'(CFG_SLOT)) |=>
      (rd_en_o && rd_addr_o == ADDR_W'(OFS_FIRST)));

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o == ADDR_W'(OFS_SLOT)) |=> (done_o && !busy_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!rd_en_o && !wr_en_o));
endmodule

bind cfg_crc_gen cfg_crc_chk #(
  .ADDR_W(ADDR_W), .CFG_SLOT(CFG_SLOT), .OFS_FIRST(OFS_FIRST), .OFS_SLOT(OFS_SLOT)
) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o),
  .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o)
);

// File: tb/tb_cfg_crc_gen.sv
`timescale 1ns/1ps
module tb_cfg_crc_gen;
  logic       clk = 1'b0;
  logic       rst, start;
  logic       busy, done, rd_en, wr_en;
  logic [4:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  always #2 clk = ~clk;

  cfg_crc_gen dut (
    .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .done_o(done),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  logic [7:0] mem [20];
  logic [7:0] img [20];
  logic       load_req = 1'b0;
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load_req) for (int i = 0; i < 20; i++) mem[i] <= img[i];
    else if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
    else       rd_data <= 8'($urandom);   // R5: junk outside the valid cycle
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] crc_ref(input int first, input int last);
    logic [7:0] c = 8'h02;
    for (int a = first; a <= last; a++) begin
      logic [7:0] d = img[a];
      for (int b = 0; b < 8; b++) begin
        if (c[7] != d[7]) c = (c << 1) ^ 8'h1D;
        else              c = c << 1;
        d = d << 1;
      end
    end
    return c;
  endfunction

  int mon_on = 0, rd_cnt, wr_cnt, last_rd, wr_cyc, start_cyc, done_seen;
  logic [7:0] exp_cfg, exp_ofs;

  always @(negedge clk) if (mon_on != 0) begin
    if (rd_en && wr_en) chk(0, "R9 rd/wr same cycle", 1, 0);
    if (rd_en) begin
      chk(int'(rd_addr) == ((rd_cnt < 12) ? rd_cnt : rd_cnt + 1), "R4 read address",
          rd_addr, (rd_cnt < 12) ? rd_cnt : rd_cnt + 1);
      if (rd_cnt == 0)       chk(cyc - start_cyc == 1, "R6 first read delay", cyc - start_cyc, 1);
      else if (rd_cnt == 12) chk(wr_cnt == 1 && cyc - wr_cyc == 1, "R4 offset after cfg write", cyc - wr_cyc, 1);
      else                   chk(cyc - last_rd == 10, "R6 read spacing", cyc - last_rd, 10);
      rd_cnt++;
      last_rd = cyc;
    end
    if (wr_en) begin
      chk(cyc - last_rd == 10, "R6 write delay", cyc - last_rd, 10);
      if (wr_cnt == 0) begin
        chk(wr_addr == 5'd12 && rd_cnt == 12, "R4/R9 cfg slot", wr_addr, 12);
        chk(wr_data == exp_cfg, "R2 cfg crc", wr_data, exp_cfg);
      end else begin
        chk(wr_addr == 5'd19 && rd_cnt == 18, "R9 ofs slot", wr_addr, 19);
        chk(wr_data == exp_ofs, "R3 ofs crc", wr_data, exp_ofs);
      end
      wr_cnt++;
      wr_cyc = cyc;
    end
    if (done) begin
      chk(done_seen == 0 && wr_cnt == 2 && cyc - wr_cyc == 1, "R7 done timing", cyc - wr_cyc, 1);
      chk(!busy, "R7 busy low at done", busy, 0);
      done_seen++;
    end
  end

  task automatic check_idle(input string req);
    chk(!busy && !rd_en && !wr_en && !done, req, {busy, rd_en, wr_en, done}, 0);
  endtask

  task automatic run(input int poke);
    logic [7:0] keep [20];
    int guard = 0;
    exp_cfg = crc_ref(0, 11);
    exp_ofs = crc_ref(13, 18);
    for (int i = 0; i < 20; i++) keep[i] = img[i];
    @(negedge clk) load_req = 1'b1;
    @(negedge clk) load_req = 1'b0;
    rd_cnt = 0; wr_cnt = 0; done_seen = 0; last_rd = 0; wr_cyc = 0;
    start_cyc = cyc;
    start = 1'b1;
    mon_on = 1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1'b1;             // R8: stray start while busy
      @(negedge clk) start = 1'b0;
    end
    while (done_seen == 0 && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    mon_on = 0;
    chk(done_seen == 1, "R7 single done", done_seen, 1);
    chk(rd_cnt == 18 && wr_cnt == 2, "R8 access count", rd_cnt * 16 + wr_cnt, 18 * 16 + 2);
    chk(mem[12] == exp_cfg, "R2 stored cfg crc", mem[12], exp_cfg);
    chk(mem[19] == exp_ofs, "R3 stored ofs crc", mem[19], exp_ofs);
    for (int i = 0; i < 20; i++)
      if (i != 12 && i != 19)
        chk(mem[i] == keep[i], "R9 other bytes untouched", mem[i], keep[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] prev_ofs;
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0;
    for (int i = 0; i < 20; i++) begin img[i] = 8'h00; mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    run(0);                                     // all zero bytes
    for (int i = 0; i < 20; i++) img[i] = 8'hFF;
    run(0);                                     // all ones
    for (int i = 0; i < 20; i++) img[i] = 8'h00;
    img[0] = 8'h80; run(0);                     // MSB-first ordering
    img[0] = 8'h01; run(0);
    img[11] = 8'hA5; img[13] = 8'h3C; img[18] = 8'h01; run(0);
    prev_ofs = exp_ofs;
    for (int i = 0; i <= 12; i++) img[i] = 8'($urandom);
    run(5);
    chk(exp_ofs == prev_ofs && mem[19] == prev_ofs, "R3 ofs independent of cfg", mem[19], prev_ofs);

    // reset in mid-job, then a clean job
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 reset mid-job");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 idle after mid-job reset");

    for (int t = 0; t < 25; t++) begin
      for (int i = 0; i < 20; i++) img[i] = 8'($urandom);
      run((t % 2 == 0) ? 1 + int'($urandom % 170) : 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule